// File: doc/BRIEF.md
# Indexed Interrupt Redirection Controller

This block routes a bank of interrupt lines to a message output. The bus sees only two 32-bit registers. One holds an index, the other is a data window into the internal register that the index names. Behind the window are an identity register, a read-only version register and one 64-bit redirection entry per interrupt line. Each entry sets the vector, the destination and the delivery mode of its message, and it chooses edge or level triggering, active-high or active-low polarity, and a mask.

Every clock the block samples its inputs and turns qualifying activity into requests. It offers the lowest-numbered pending request on a valid/ready message port. The priority the receiver gives a message is taken from its vector number alone, so this block adds no priority field. A level-triggered line that has been delivered stays blocked until an end-of-interrupt carrying the same vector is seen.

Top module: `irq_route_ctl`

## Requirements
- R1: Bus address 0 is the index register. Writes keep bits 7:0. A read returns the stored index in bits 7:0 and zero in bits 31:8.
- R2: Bus address 1 is the window. It reads and writes the internal register named by the current index. Internal indices 0x02 to 0x0F, and 0x10+2*NUM_IN and above, read as zero, and writes to them change nothing.
- R3: Index 0x00 holds a 4-bit identity in bits 27:24, and no other bit of it can be written. Index 0x01 reads NUM_IN-1 in bits 23:16 and 0x20 in bits 7:0, and ignores writes.
- R4: Entry k uses index 0x10+2k for its low word and 0x11+2k for its high word. Low word: vector 7:0, mode 10:8, delivery status 12, polarity 13 (1 = active low), remote pending 14, trigger 15 (1 = level), mask 16. High word: destination 31:24. After reset every low word reads 0x00010000 (masked) and no message is offered. A masked entry offers no message, and an edge that arrives while it is masked is dropped.
- R5: An edge-triggered entry raises exactly one request each time its line enters the active level, whichever polarity is selected.
- R6: Delivering a level-triggered entry sets its remote-pending bit. While that bit is set the entry is not delivered again. An end-of-interrupt whose vector equals the entry's vector clears the bit. An end-of-interrupt with any other vector leaves it set.
- R7: The delivery-status bit, which is read-only, is 1 while the entry's request waits for the handshake.
- R8: When several entries are pending, the lowest-numbered one is offered first, and each accepted handshake delivers exactly one message.
- R9: The message carries the vector, destination and mode of the entry it came from.
- R10: A level request that has not been delivered is withdrawn when its line returns to the inactive level.
- R11: If an end-of-interrupt matching an entry's vector arrives in the same cycle as that entry's delivery, the remote-pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 1 | 0 selects the index register, 1 selects the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, same cycle |
| irq_in | input | NUM_IN | Interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_mode | output | 3 | Message delivery mode |

## Verification
The hardest overlap is an end-of-interrupt arriving in the same cycle as the handshake that delivers that same level entry again. One event sets the remote-pending bit and the other clears it. The bench holds a level line active with ready low, so the request waits. It then raises ready and strobes the matching end-of-interrupt on the same edge. It judges the result by reading the entry back through the window, which must show remote pending set. The scoreboard confirms that exactly one message left and that no second one follows while the line stays high.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int MODE_W = 3;

    // fixed internal index map
    localparam logic [7:0] IX_IDENT = 8'h00;
    localparam logic [7:0] IX_VERS  = 8'h01;
    localparam logic [7:0] IX_TABLE = 8'h10;
    localparam logic [7:0] VERS_CODE = 8'h20;

    // one routing entry as held in storage (read-only bits kept elsewhere)
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              act_low;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } route_t;

    localparam route_t ROUTE_RST = '{dest: '0, mask: 1'b1, level: 1'b0,
                                     act_low: 1'b0, mode: '0, vector: '0};

    function automatic logic [31:0] pack_low(route_t e, logic busy, logic held);
        logic [31:0] w;
        w        = '0;
        w[7:0]   = e.vector;
        w[10:8]  = e.mode;
        w[12]    = busy;
        w[13]    = e.act_low;
        w[14]    = held;
        w[15]    = e.level;
        w[16]    = e.mask;
        return w;
    endfunction

    function automatic route_t unpack_low(route_t old, logic [31:0] w);
        route_t e;
        e         = old;
        e.vector  = w[7:0];
        e.mode    = w[10:8];
        e.act_low = w[13];
        e.level   = w[15];
        e.mask    = w[16];
        return e;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_IN = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_IN-1:0] pend,
    input  logic [NUM_IN-1:0] grant,
    input  logic              eoi_valid,
    input  logic [VEC_W-1:0]  eoi_vector,
    output route_t            cfg [NUM_IN],
    output logic [NUM_IN-1:0] remote,
    output logic [7:0]        win_idx
);
    localparam logic [7:0] TABLE_END = 8'(int'(IX_TABLE) + 2 * NUM_IN);
    localparam logic [7:0] TOP_ENTRY = 8'(NUM_IN - 1);

    logic [7:0]        idx_q;
    logic [3:0]        ident_q;
    route_t            tbl_q [NUM_IN];
    logic [NUM_IN-1:0] held_q;

    logic       in_table;
    logic [7:0] ent;
    logic       upper;
    logic       win_we;

    assign in_table = (idx_q >= IX_TABLE) && (idx_q < TABLE_END);
    assign ent      = (idx_q - IX_TABLE) >> 1;
    assign upper    = idx_q[0];
    assign win_we   = bus_we && bus_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            ident_q <= '0;
            held_q  <= '0;
            for (int k = 0; k < NUM_IN; k++) tbl_q[k] <= ROUTE_RST;
        end else begin
            if (bus_we && !bus_addr) idx_q <= bus_wdata[7:0];
            if (win_we && idx_q == IX_IDENT) ident_q <= bus_wdata[27:24];
            for (int k = 0; k < NUM_IN; k++) begin
                if (win_we && in_table && ent == 8'(k)) begin
                    if (upper) tbl_q[k].dest <= bus_wdata[31:24];
                    else       tbl_q[k] <= unpack_low(tbl_q[k], bus_wdata);
                end
                // a new delivery wins over a same-cycle retire
                if (grant[k] && tbl_q[k].level)
                    held_q[k] <= 1'b1;
                else if (eoi_valid && tbl_q[k].level && eoi_vector == tbl_q[k].vector)
                    held_q[k] <= 1'b0;
            end
        end
    end

    // window read
    always_comb begin
        logic [31:0] w;
        w = '0;
        if (idx_q == IX_IDENT) begin
            w[27:24] = ident_q;
        end else if (idx_q == IX_VERS) begin
            w[23:16] = TOP_ENTRY;
            w[7:0]   = VERS_CODE;
        end else if (in_table) begin
            for (int k = 0; k < NUM_IN; k++) begin
                if (ent == 8'(k)) begin
                    if (upper) w[31:24] = tbl_q[k].dest;
                    else       w = pack_low(tbl_q[k], pend[k], held_q[k]);
                end
            end
        end
        bus_rdata = bus_addr ? w : {24'h0, idx_q};
    end

    assign cfg     = tbl_q;
    assign remote  = held_q;
    assign win_idx = idx_q;

endmodule

// File: rtl/irq_route_detect.sv
`timescale 1ns/1ps
module irq_route_detect
    import irq_route_pkg::*;
#(
    parameter int NUM_IN = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  route_t            cfg [NUM_IN],
    input  logic [NUM_IN-1:0] remote,
    input  logic [NUM_IN-1:0] grant,
    output logic [NUM_IN-1:0] pend
);
    logic [NUM_IN-1:0] act, msk, lvl;
    logic [NUM_IN-1:0] prev_q, pend_q;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
        assign act[i] = irq_in[i] ^ cfg[i].act_low;
        assign msk[i] = cfg[i].mask;
        assign lvl[i] = cfg[i].level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= act;
            for (int i = 0; i < NUM_IN; i++) begin
                if (lvl[i])
                    pend_q[i] <= act[i] & ~msk[i] & ~remote[i] & ~grant[i];
                else
                    pend_q[i] <= (pend_q[i] & ~grant[i]) | (act[i] & ~prev_q[i] & ~msk[i]);
            end
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_route_arb.sv
`timescale 1ns/1ps
module irq_route_arb
    import irq_route_pkg::*;
#(
    parameter int NUM_IN = 24
) (
    input  logic              msg_ready,
    input  logic [NUM_IN-1:0] pend,
    input  route_t            cfg [NUM_IN],
    output logic              msg_valid,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [DEST_W-1:0] msg_dest,
    output logic [MODE_W-1:0] msg_mode,
    output logic [NUM_IN-1:0] grant
);
    logic [NUM_IN-1:0] req, pick;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_req
        assign req[i] = pend[i] & ~cfg[i].mask;
    end

    // isolate the lowest set bit
    assign pick      = req & (~req + 1'b1);
    assign msg_valid = |req;
    assign grant     = pick & {NUM_IN{msg_ready}};

    always_comb begin
        msg_vector = '0;
        msg_dest   = '0;
        msg_mode   = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (pick[i]) begin
                msg_vector = msg_vector | cfg[i].vector;
                msg_dest   = msg_dest   | cfg[i].dest;
                msg_mode   = msg_mode   | cfg[i].mode;
            end
        end
    end

endmodule

// File: rtl/irq_route_ctl.sv
`timescale 1ns/1ps
module irq_route_ctl
    import irq_route_pkg::*;
#(
    parameter int NUM_IN = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [7:0]        msg_dest,
    output logic [2:0]        msg_mode
);
    route_t            cfg [NUM_IN];
    logic [NUM_IN-1:0] pend, remote, grant;
    logic [7:0]        win_idx;

    irq_route_regs #(.NUM_IN(NUM_IN)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend),
        .grant(grant), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .cfg(cfg), .remote(remote), .win_idx(win_idx)
    );

    irq_route_detect #(.NUM_IN(NUM_IN)) u_detect (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg(cfg),
        .remote(remote), .grant(grant), .pend(pend)
    );

    irq_route_arb #(.NUM_IN(NUM_IN)) u_arb (
        .msg_ready(msg_ready), .pend(pend), .cfg(cfg),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_dest(msg_dest),
        .msg_mode(msg_mode), .grant(grant)
    );

endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk #(
    parameter int NUM_IN = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [NUM_IN-1:0] pend,
    input logic [NUM_IN-1:0] remote,
    input logic [7:0]        win_idx
);
    localparam logic [7:0] TABLE_END = 8'(16 + 2 * NUM_IN);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !msg_valid); // R4

    AST_INDEX_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_addr |-> bus_rdata[31:8] == 24'h0); // R1

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr && ((win_idx >= 8'h02 && win_idx < 8'h10) || win_idx >= TABLE_END))
        |-> bus_rdata == 32'h0); // R2

    AST_HELD_ONLY_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        ((remote & ~$past(remote)) != '0) |-> $past(msg_valid && msg_ready)); // R6

    AST_ONE_PER_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        $countones(remote & ~$past(remote)) <= 1); // R8

    AST_OFFER_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> pend != '0); // R7

endmodule

bind irq_route_ctl irq_route_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .pend(pend),
    .remote(remote), .win_idx(win_idx)
);

// File: tb/irq_route_ctl_test.sv
`timescale 1ns/1ps
module irq_route_ctl_test;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0, bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid, msg_ready = 1'b1;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_mode;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [18:0] sb [$];

    always #10 clk = ~clk;

    irq_route_ctl #(.NUM_IN(N)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
        .msg_mode(msg_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic a, input logic [31:0] d);
        step(1);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_we = 1'b0;
    endtask

    task automatic win_wr(input logic [7:0] ix, input logic [31:0] d);
        bus_wr(1'b0, {24'h0, ix});
        bus_wr(1'b1, d);
    endtask

    task automatic win_rd(input string tag, input logic [7:0] ix, input logic [31:0] exp);
        bus_wr(1'b0, {24'h0, ix});
        bus_addr = 1'b1;
        @(negedge clk);
        check(tag, bus_rdata, exp);
    endtask

    task automatic expect_msg(input logic [7:0] v, input logic [7:0] d, input logic [2:0] m);
        sb.push_back({m, d, v});
    endtask

    task automatic retire(input logic [7:0] v);
        step(1);
        eoi_valid = 1'b1; eoi_vector = v;
        step(1);
        eoi_valid = 1'b0;
    endtask

    // monitor: every accepted message is matched against the scoreboard
    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R5/R6/R8: unexpected message got %h expected none",
                         {msg_mode, msg_dest, msg_vector});
            end else begin
                logic [18:0] e;
                e = sb.pop_front();
                if ({msg_mode, msg_dest, msg_vector} !== e) begin
                    n_fail++;
                    $display("FAIL R9: message got %h expected %h",
                             {msg_mode, msg_dest, msg_vector}, e);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // reset state
        @(negedge clk);
        check("R1 reset index", bus_rdata, 32'h0);
        check("R4 reset no message", {31'h0, msg_valid}, 32'h0);
        win_rd("R4 entry0 masked at reset", 8'h10, 32'h0001_0000);

        // R1 index register
        bus_wr(1'b0, 32'hABCD_EF12);
        bus_addr = 1'b0;
        @(negedge clk);
        check("R1 index readback", bus_rdata, 32'h0000_0012);

        // R3 identity and version
        win_wr(8'h00, 32'hFFFF_FFFF);
        win_rd("R3 identity", 8'h00, 32'h0F00_0000);
        win_wr(8'h01, 32'hFFFF_FFFF);
        win_rd("R3 version", 8'h01, 32'h0017_0020);

        // R2 holes
        win_wr(8'h05, 32'hFFFF_FFFF);
        win_rd("R2 hole 0x05", 8'h05, 32'h0);
        win_wr(8'h40, 32'hFFFF_FFFF);
        win_rd("R2 hole 0x40", 8'h40, 32'h0);
        win_rd("R2 entry0 untouched", 8'h10, 32'h0001_0000);

        // R5 edge, active high: entry 3
        win_wr(8'h17, 32'h0200_0000);
        win_wr(8'h16, 32'h0000_0041);
        win_rd("R2 entry3 low", 8'h16, 32'h0000_0041);
        win_rd("R2 entry3 high", 8'h17, 32'h0200_0000);
        expect_msg(8'h41, 8'h02, 3'd0);
        irq_in[3] = 1'b1; step(10);
        irq_in[3] = 1'b0; step(5);
        check("R5 single edge message", sb.size(), 0);

        // R5 edge, active low: entry 5
        irq_in[5] = 1'b1;
        win_wr(8'h1B, 32'h0300_0000);
        win_wr(8'h1A, 32'h0001_2052);
        win_wr(8'h1A, 32'h0000_2052);
        step(3);
        expect_msg(8'h52, 8'h03, 3'd0);
        irq_in[5] = 1'b0; step(6);
        irq_in[5] = 1'b1; step(6);
        check("R5 active-low edge", sb.size(), 0);

        // R6 level entry 7
        win_wr(8'h1F, 32'h0400_0000);
        win_wr(8'h1E, 32'h0000_8163);
        expect_msg(8'h63, 8'h04, 3'd1);
        irq_in[7] = 1'b1; step(6);
        win_rd("R6 remote set", 8'h1E, 32'h0000_C163);
        step(15);
        retire(8'h64); step(5);
        check("R6 wrong vector keeps block", sb.size(), 0);
        win_rd("R6 remote still set", 8'h1E, 32'h0000_C163);
        expect_msg(8'h63, 8'h04, 3'd1);
        retire(8'h63); step(6);
        check("R6 redelivery after retire", sb.size(), 0);
        irq_in[7] = 1'b0;
        retire(8'h63); step(3);
        win_rd("R6 remote cleared", 8'h1E, 32'h0000_8163);

        // R7 / R8 status and ordering
        msg_ready = 1'b0;
        irq_in[5] = 1'b0;
        irq_in[3] = 1'b1;
        step(3);
        win_rd("R7 status entry5", 8'h1A, 32'h0000_3052);
        @(negedge clk);
        check("R8 lowest offered valid", {31'h0, msg_valid}, 32'h1);
        check("R8 lowest offered vector", {24'h0, msg_vector}, 32'h41);
        irq_in[5] = 1'b1;
        irq_in[3] = 1'b0;
        expect_msg(8'h41, 8'h02, 3'd0);
        expect_msg(8'h52, 8'h03, 3'd0);
        step(1);
        msg_ready = 1'b1;
        step(6);
        check("R8 both delivered in order", sb.size(), 0);
        win_rd("R7 status cleared", 8'h1A, 32'h0000_2052);

        // R10 level withdrawn
        msg_ready = 1'b0;
        irq_in[7] = 1'b1; step(2);
        win_rd("R10 level pending", 8'h1E, 32'h0000_9163);
        irq_in[7] = 1'b0; step(2);
        win_rd("R10 level withdrawn", 8'h1E, 32'h0000_8163);
        msg_ready = 1'b1; step(5);

        // R4 mask drops edges
        win_wr(8'h16, 32'h0001_0041);
        irq_in[3] = 1'b1; step(3);
        irq_in[3] = 1'b0; step(3);
        win_rd("R4 masked edge dropped", 8'h16, 32'h0001_0041);

        // R11 retire collides with delivery
        msg_ready = 1'b0;
        irq_in[7] = 1'b1; step(3);
        expect_msg(8'h63, 8'h04, 3'd1);
        msg_ready = 1'b1; eoi_valid = 1'b1; eoi_vector = 8'h63;
        step(1);
        eoi_valid = 1'b0;
        step(8);
        win_rd("R11 remote set after collision", 8'h1E, 32'h0000_C163);
        check("R11 single message", sb.size(), 0);
        irq_in[7] = 1'b0;
        retire(8'h63); step(3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule